// File: doc/BRIEF.md
# Framebuffer Scan-out Mode Resolver

This unit turns the raw display programming into a checked scan-out geometry. Every clock it reads the display enable word, the colour depth, the visible resolution, the virtual line width, the horizontal and vertical pan values, the byte-order flag and the configured video memory size. From these it derives the pixel format code, bytes per pixel, line stride, start offset and total frame size. It then decides whether that geometry can safely be scanned out of video memory.

The verdict and the geometry are registered, so they appear one cycle after the inputs. A geometry is accepted only when every check passes. When it differs from the last accepted geometry, it is captured and a one-cycle change pulse is raised so that a downstream fetch engine can rebuild its surface. While the programming is invalid, or unchanged, the geometry outputs keep showing the last captured mode.

Top module: `fbm_top`

## Requirements
- R1: The mode is valid only when bit 0 of `dispEnable` is set. The other bits of that word have no effect.
- R2: A depth of 16 gives format code 1 (RGB 5-6-5, native order) with 2 bytes per pixel. A depth of 32 gives format code 2 (xRGB 8-8-8-8 little-endian) when `bigEndian` is 0, and code 3 (big-endian) when it is 1, with 4 bytes per pixel. Any other depth makes the mode invalid.
- R3: When `virtWidth` is below `xRes`, the effective line width is `xRes`. Otherwise it is `virtWidth`.
- R4: `lineStride` equals effective line width times bytes per pixel. `frameSize` equals `lineStride` times `yRes`.
- R5: `startOffset` equals `xPan` times bytes per pixel plus `yPan` times `lineStride`, computed without truncation.
- R6: A width or a height below 64 makes the mode invalid. A width and height of exactly 64 are accepted.
- R7: The memory size is rounded up to the next power of two. The mode is invalid when `startOffset + frameSize` exceeds that rounded size. An exact fit is accepted.
- R8: A configured memory size below 4 MiB or above 256 MiB makes the mode invalid.
- R9: `modeValid` reflects the inputs of the previous cycle. `modeChanged` pulses for one cycle when a valid mode is the first one captured, or when it differs in any field from the captured mode; the new mode then appears on the outputs. In all other cycles the geometry outputs hold.
- R10: After reset, `modeValid` and `modeChanged` are 0 and all geometry outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispEnable | input | 16 | Enable word, bit 0 enables display |
| bitsPerPixel | input | 16 | Programmed colour depth |
| xRes | input | 16 | Visible width in pixels |
| yRes | input | 16 | Visible height in lines |
| virtWidth | input | 16 | Virtual line width in pixels |
| xPan | input | 16 | Horizontal pan in pixels |
| yPan | input | 16 | Vertical pan in lines |
| bigEndian | input | 1 | Byte order for 32-bit pixels |
| memBytes | input | 32 | Configured video memory size in bytes |
| modeValid | output | 1 | Previous cycle's programming forms a valid mode |
| modeChanged | output | 1 | One-cycle pulse on capture of a new mode |
| pixFormat | output | 2 | Captured format code |
| bytesPerPixel | output | 3 | Captured bytes per pixel |
| outWidth | output | 16 | Captured width |
| outHeight | output | 16 | Captured height |
| lineStride | output | 18 | Captured stride in bytes |
| startOffset | output | 40 | Captured start offset in bytes |
| frameSize | output | 40 | Captured frame size in bytes |

## Verification
The assertions check the following on every cycle: a change pulse only comes with a valid verdict, the captured geometry holds between pulses, a valid mode never shows a dimension below 64 or a stride narrower than its visible line, and the format code agrees with the bytes per pixel. The exact arithmetic can only be shown by the bench's scenarios. These cover clamping of the virtual width, offsets built from both pans, the exact-fit and one-line-over memory cases, rounding of an odd memory size, the memory range limits and the rejected depths. The scenarios also show that returning to an already captured mode raises no second pulse.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  localparam int REG_W    = 16;
  localparam int BPP_W    = 3;
  localparam int STRIDE_W = REG_W + 2;
  localparam int SPAN_W   = 40;
  localparam int MEM_W    = 32;

  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    pix_fmt_e                fmt;
    logic [BPP_W-1:0]        bpp;
    logic [REG_W-1:0]        width;
    logic [REG_W-1:0]        height;
    logic [STRIDE_W-1:0]     stride;
    logic [SPAN_W-1:0]       offset;
    logic [SPAN_W-1:0]       size;
  } fb_mode_t;

  typedef struct packed {
    logic capture;
  } mode_strobe_t;
endpackage

// File: rtl/fbm_datapath.sv
module fbm_datapath
  import fbm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  mode_strobe_t        strobe,
  input  logic [REG_W-1:0]    bitsPerPixel,
  input  logic [REG_W-1:0]    xRes,
  input  logic [REG_W-1:0]    yRes,
  input  logic [REG_W-1:0]    virtWidth,
  input  logic [REG_W-1:0]    xPan,
  input  logic [REG_W-1:0]    yPan,
  input  logic                bigEndian,
  input  logic [MEM_W-1:0]    memBytes,
  output fb_mode_t            cand,
  output fb_mode_t            held,
  output logic                depthOk,
  output logic [SPAN_W:0]     candEnd,
  output logic [MEM_W:0]      memCeil
);
  logic [REG_W-1:0]  effWidth;
  logic [MEM_W-1:0]  smear;

  always_comb begin
    cand    = '0;
    depthOk = 1'b0;
    case (bitsPerPixel)
      REG_W'(16): begin
        cand.fmt = FMT_RGB565;
        cand.bpp = BPP_W'(2);
        depthOk  = 1'b1;
      end
      REG_W'(32): begin
        cand.fmt = bigEndian ? FMT_XRGB_BE : FMT_XRGB_LE;
        cand.bpp = BPP_W'(4);
        depthOk  = 1'b1;
      end
      default: begin
        cand.fmt = FMT_NONE;
        cand.bpp = '0;
      end
    endcase
    effWidth    = (virtWidth < xRes) ? xRes : virtWidth;
    cand.width  = xRes;
    cand.height = yRes;
    cand.stride = STRIDE_W'(effWidth) * STRIDE_W'(cand.bpp);
    cand.size   = SPAN_W'(cand.stride) * SPAN_W'(yRes);
    cand.offset = SPAN_W'(xPan) * SPAN_W'(cand.bpp)
                + SPAN_W'(yPan) * SPAN_W'(cand.stride);
    candEnd     = (SPAN_W+1)'(cand.offset) + (SPAN_W+1)'(cand.size);
  end

  always_comb begin
    smear = memBytes - MEM_W'(1);
    for (int sh = 1; sh < MEM_W; sh = sh * 2) begin
      smear = smear | (smear >> sh);
    end
    memCeil = {1'b0, smear} + (MEM_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
    end else if (strobe.capture) begin
      held <= cand;
    end
  end

  assert_fmt_matches_bpp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (held.fmt == FMT_RGB565) |-> (held.bpp == BPP_W'(2)));
  assert_wide_fmt_bpp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (held.bpp == BPP_W'(4)) |-> (held.fmt == FMT_XRGB_LE || held.fmt == FMT_XRGB_BE));
endmodule

// File: rtl/fbm_ctrl.sv
module fbm_ctrl
  import fbm_pkg::*;
#(
  parameter int MIN_DIM = 64,
  parameter logic [MEM_W-1:0] MEM_MIN = 32'd4194304,
  parameter logic [MEM_W-1:0] MEM_MAX = 32'd268435456
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enBit,
  input  logic             depthOk,
  input  fb_mode_t         cand,
  input  fb_mode_t         held,
  input  logic [SPAN_W:0]  candEnd,
  input  logic [MEM_W:0]   memCeil,
  input  logic [MEM_W-1:0] memBytes,
  output mode_strobe_t     strobe,
  output logic             modeValid,
  output logic             modeChanged
);
  localparam logic [REG_W-1:0] MIN_DIM_V = REG_W'(MIN_DIM);

  logic heldAny;
  logic dimsOk;
  logic memRangeOk;
  logic fitsOk;
  logic candOk;
  logic differs;

  always_comb begin
    dimsOk     = (cand.width >= MIN_DIM_V) && (cand.height >= MIN_DIM_V);
    memRangeOk = (memBytes >= MEM_MIN) && (memBytes <= MEM_MAX);
    fitsOk     = candEnd <= (SPAN_W+1)'(memCeil);
    candOk     = enBit && depthOk && dimsOk && memRangeOk && fitsOk;
    differs    = !heldAny || (cand != held);
    strobe.capture = candOk && differs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeValid   <= 1'b0;
      modeChanged <= 1'b0;
      heldAny     <= 1'b0;
    end else begin
      modeValid   <= candOk;
      modeChanged <= strobe.capture;
      heldAny     <= heldAny | strobe.capture;
    end
  end

  assert_pulse_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> modeValid);
  assert_valid_has_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> heldAny);
endmodule

// File: rtl/fbm_top.sv
module fbm_top
  import fbm_pkg::*;
#(
  parameter int MIN_DIM = 64,
  parameter logic [MEM_W-1:0] MEM_MIN = 32'd4194304,
  parameter logic [MEM_W-1:0] MEM_MAX = 32'd268435456
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_W-1:0]     dispEnable,
  input  logic [REG_W-1:0]     bitsPerPixel,
  input  logic [REG_W-1:0]     xRes,
  input  logic [REG_W-1:0]     yRes,
  input  logic [REG_W-1:0]     virtWidth,
  input  logic [REG_W-1:0]     xPan,
  input  logic [REG_W-1:0]     yPan,
  input  logic                 bigEndian,
  input  logic [MEM_W-1:0]     memBytes,
  output logic                 modeValid,
  output logic                 modeChanged,
  output logic [1:0]           pixFormat,
  output logic [BPP_W-1:0]     bytesPerPixel,
  output logic [REG_W-1:0]     outWidth,
  output logic [REG_W-1:0]     outHeight,
  output logic [STRIDE_W-1:0]  lineStride,
  output logic [SPAN_W-1:0]    startOffset,
  output logic [SPAN_W-1:0]    frameSize
);
  fb_mode_t        cand;
  fb_mode_t        held;
  mode_strobe_t    strobe;
  logic            depthOk;
  logic [SPAN_W:0] candEnd;
  logic [MEM_W:0]  memCeil;

  fbm_datapath datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bitsPerPixel(bitsPerPixel), .xRes(xRes), .yRes(yRes),
    .virtWidth(virtWidth), .xPan(xPan), .yPan(yPan),
    .bigEndian(bigEndian), .memBytes(memBytes),
    .cand(cand), .held(held), .depthOk(depthOk),
    .candEnd(candEnd), .memCeil(memCeil)
  );

  fbm_ctrl #(.MIN_DIM(MIN_DIM), .MEM_MIN(MEM_MIN), .MEM_MAX(MEM_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .enBit(dispEnable[0]), .depthOk(depthOk),
    .cand(cand), .held(held), .candEnd(candEnd), .memCeil(memCeil),
    .memBytes(memBytes), .strobe(strobe),
    .modeValid(modeValid), .modeChanged(modeChanged)
  );

  assign pixFormat     = held.fmt;
  assign bytesPerPixel = held.bpp;
  assign outWidth      = held.width;
  assign outHeight     = held.height;
  assign lineStride    = held.stride;
  assign startOffset   = held.offset;
  assign frameSize     = held.size;

  assert_hold_between_pulses_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeChanged |-> ($stable(outWidth) && $stable(lineStride) && $stable(startOffset)));
  assert_min_dims_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (outWidth >= REG_W'(MIN_DIM) && outHeight >= REG_W'(MIN_DIM)));
  assert_stride_covers_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (lineStride >= STRIDE_W'(outWidth) * STRIDE_W'(bytesPerPixel)));
endmodule

// File: tb/fbm_top_tb_top.sv
module fbm_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dispEnable = '0, bitsPerPixel = '0, xRes = '0, yRes = '0;
  logic [15:0] virtWidth = '0, xPan = '0, yPan = '0;
  logic        bigEndian = 1'b0;
  logic [31:0] memBytes = '0;
  logic        modeValid, modeChanged;
  logic [1:0]  pixFormat;
  logic [2:0]  bytesPerPixel;
  logic [15:0] outWidth, outHeight;
  logic [17:0] lineStride;
  logic [39:0] startOffset, frameSize;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic        valid, changed;
    logic [1:0]  fmt;
    logic [2:0]  bpp;
    logic [15:0] w, h;
    logic [17:0] stride;
    logic [39:0] off, size;
    string       tag;
  } exp_t;

  exp_t scoreQ[$];
  logic        mHave = 0;
  logic [1:0]  mFmt = 0;
  logic [2:0]  mBpp = 0;
  logic [15:0] mW = 0, mH = 0;
  logic [17:0] mStride = 0;
  logic [39:0] mOff = 0, mSize = 0;

  localparam int MIB = 1048576;

  always #5 clk = ~clk;

  fbm_top dut_i (
    .clk(clk), .rstN(rstN), .dispEnable(dispEnable), .bitsPerPixel(bitsPerPixel),
    .xRes(xRes), .yRes(yRes), .virtWidth(virtWidth), .xPan(xPan), .yPan(yPan),
    .bigEndian(bigEndian), .memBytes(memBytes), .modeValid(modeValid),
    .modeChanged(modeChanged), .pixFormat(pixFormat), .bytesPerPixel(bytesPerPixel),
    .outWidth(outWidth), .outHeight(outHeight), .lineStride(lineStride),
    .startOffset(startOffset), .frameSize(frameSize)
  );

  task automatic drive(string tag, logic [15:0] en, logic [15:0] depth,
                       logic [15:0] xr, logic [15:0] yr, logic [15:0] vw,
                       logic [15:0] xp, logic [15:0] yp, logic be, logic [31:0] mem);
    exp_t e;
    logic ok;
    logic [1:0] f;
    longint unsigned b, evw, st, sz, of, p;
    @(negedge clk);
    dispEnable = en; bitsPerPixel = depth; xRes = xr; yRes = yr;
    virtWidth = vw; xPan = xp; yPan = yp; bigEndian = be; memBytes = mem;
    ok = en[0];
    if (depth == 16) begin f = 2'd1; b = 2; end
    else if (depth == 32) begin f = be ? 2'd3 : 2'd2; b = 4; end
    else begin f = 2'd0; b = 0; ok = 0; end
    evw = (vw < xr) ? xr : vw;
    st = evw * b;
    sz = st * yr;
    of = xp * b + yp * st;
    if (xr < 64 || yr < 64) ok = 0;
    if (mem < 4 * MIB || mem > 256 * MIB) ok = 0;
    p = 1;
    while (p < mem) p = p << 1;
    if (of + sz > p) ok = 0;
    e.valid = ok;
    e.changed = ok && (!mHave || f != mFmt || b[2:0] != mBpp || xr != mW || yr != mH ||
                       st[17:0] != mStride || of[39:0] != mOff || sz[39:0] != mSize);
    if (e.changed) begin
      mHave = 1; mFmt = f; mBpp = b[2:0]; mW = xr; mH = yr;
      mStride = st[17:0]; mOff = of[39:0]; mSize = sz[39:0];
    end
    e.fmt = mFmt; e.bpp = mBpp; e.w = mW; e.h = mH;
    e.stride = mStride; e.off = mOff; e.size = mSize; e.tag = tag;
    scoreQ.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        e = scoreQ.pop_front();
        checks++;
        if ({modeValid, modeChanged, pixFormat, bytesPerPixel, outWidth, outHeight,
             lineStride, startOffset, frameSize} !==
            {e.valid, e.changed, e.fmt, e.bpp, e.w, e.h, e.stride, e.off, e.size}) begin
          fails++;
          $display("FAIL %s: actual v=%0b c=%0b f=%0d b=%0d w=%0d h=%0d st=%0d of=%0d sz=%0d expected v=%0b c=%0b f=%0d b=%0d w=%0d h=%0d st=%0d of=%0d sz=%0d",
                   e.tag, modeValid, modeChanged, pixFormat, bytesPerPixel, outWidth,
                   outHeight, lineStride, startOffset, frameSize, e.valid, e.changed,
                   e.fmt, e.bpp, e.w, e.h, e.stride, e.off, e.size);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checks++;
    if ({modeValid, modeChanged, outWidth, lineStride, startOffset, frameSize} !== '0) begin
      fails++;
      $display("FAIL R10: actual v=%0b c=%0b w=%0d expected all zero", modeValid, modeChanged, outWidth);
    end
    drive("R1 enable clear", 16'h0040, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    drive("R3 R4 R9 first capture", 16'h0041, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    drive("R9 no repeat pulse", 16'h0001, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    drive("R2 big-endian code", 16'h0001, 32, 640, 480, 0, 0, 0, 1, 16 * MIB);
    drive("R2 R4 565 wide virtual", 16'h0001, 16, 800, 600, 1024, 0, 0, 0, 16 * MIB);
    drive("R2 depth 24 rejected", 16'h0001, 24, 800, 600, 1024, 0, 0, 0, 16 * MIB);
    drive("R2 depth 8 rejected", 16'h0001, 8, 800, 600, 1024, 0, 0, 0, 16 * MIB);
    drive("R9 return no pulse", 16'h0001, 16, 800, 600, 1024, 0, 0, 0, 16 * MIB);
    drive("R5 both pans", 16'h0001, 16, 800, 600, 1024, 3, 5, 0, 16 * MIB);
    drive("R6 width 63", 16'h0001, 32, 63, 100, 0, 0, 0, 0, 16 * MIB);
    drive("R6 height 63", 16'h0001, 32, 100, 63, 0, 0, 0, 0, 16 * MIB);
    drive("R6 R3 64x64 clamp", 16'h0001, 32, 64, 64, 10, 0, 0, 0, 16 * MIB);
    drive("R7 exact fit odd size", 16'h0001, 32, 1024, 2048, 1024, 0, 0, 0, 5 * MIB);
    drive("R7 one line over", 16'h0001, 32, 1024, 2048, 1024, 0, 1, 0, 5 * MIB);
    drive("R7 pixel over", 16'h0001, 32, 1024, 2048, 1024, 1, 0, 0, 8 * MIB);
    drive("R8 memory too small", 16'h0001, 32, 640, 480, 0, 0, 0, 0, 3 * MIB);
    drive("R8 memory too big", 16'h0001, 32, 640, 480, 0, 0, 0, 0, 257 * MIB);
    drive("R8 memory at max", 16'h0001, 32, 640, 480, 0, 2, 2, 0, 256 * MIB);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule